// File: doc/BRIEF.md
# Low-Speed Oscillator Control Register

This block is a 32-bit control and status register for a low-speed clock controller in the backup domain. It holds the configuration for an external 32 kHz crystal oscillator: enable, bypass, drive strength, glitch filter and trim. It also holds an enable for a low-speed system clock derived from that oscillator, a clock-security enable with a failure flag, and the enable and predivider of an internal low-speed oscillator. Each oscillator is represented by a tick input that pulses once per oscillator period, in step with the bus clock. The ready flags are modelled by counting these ticks.

Software reaches the register through a single write strobe and a combinational read word. Each access carries a secure attribute and a privileged attribute. The external-oscillator fields and the internal-oscillator fields form two groups, and each group can be marked secure on its own. Configuration fields that must not change while an oscillator runs are locked by hardware. The security enable stays set until a failure has been seen.

Top module: `lsc_ctrl_reg`

## Requirements
- R1: Field positions: external enable bit 0, external ready bit 1, bypass bit 2, drive bits 4:3, security enable bit 5, failure flag bit 6, system-clock enable bit 7, system-clock ready bit 8, glitch filter bit 9, trim bits 10 upward (TRIM_W wide), internal enable bit 16, internal ready bit 17, predivider bit 18. When the external oscillator may run, the external ready flag rises on the XRISE-th (8) external tick. After the enable is cleared, the flag falls on the XFALL-th (6) external tick.
- R2: With the system-clock enable set and the external ready flag high, the system-clock ready flag rises on the second external tick. It falls one clock after the enable has been cleared or the external ready flag has dropped.
- R3: Writes to bypass, glitch filter and trim take effect only while both the external enable and the external ready flag are 0. Otherwise they are ignored.
- R4: With bypass 0 and drive 0, setting the external enable never raises the external ready flag. The oscillator enable output stays 0.
- R5: The security enable can be set only while the external ready flag is 1. Once set, a write of 0 clears it only when the failure flag is 1.
- R6: The failure flag is set by a failure pulse while the security enable is 1. It is 0 whenever the security enable is 0, and a pulse that arrives while the enable is 0 is ignored.
- R7: After the internal enable is cleared, the internal ready flag falls on the IFALL-th (3) internal tick. It rises on the IRISE-th (4) internal tick after the enable is set. It is held at 1 one clock after a watchdog-use or RTC-use input goes high.
- R8: The predivider accepts a write only when the internal enable, the internal ready flag and both use inputs are all 0.
- R9: When a group is marked secure, a non-secure access reads that group as 0 and its writes are dropped. When privileged-only mode is set, a non-privileged access is treated the same way for both groups. No error is reported in either case.
- R10: Reset loads trim from the calibration input. A pulse on the option-load input reloads it, and this reload takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data |
| acc_sec_i | input | 1 | Access is secure |
| acc_priv_i | input | 1 | Access is privileged |
| ext_sec_i | input | 1 | External-oscillator group is secure |
| int_sec_i | input | 1 | Internal-oscillator group is secure |
| priv_only_i | input | 1 | Only privileged accesses reach the register |
| rdata_o | output | 32 | Read word, filtered by access attributes |
| lse_tick_i | input | 1 | One pulse per external oscillator period |
| lsi_tick_i | input | 1 | One pulse per internal oscillator period |
| css_fail_i | input | 1 | Failure-detect pulse from the clock monitor |
| wdg_use_i | input | 1 | Watchdog uses the internal oscillator |
| rtc_use_i | input | 1 | RTC uses the internal oscillator |
| trim_cal_i | input | TRIM_W | Factory trim calibration value |
| opt_load_i | input | 1 | Option-load event, reloads trim |
| lse_en_o | output | 1 | External oscillator run enable |
| lsi_en_o | output | 1 | Internal oscillator run enable |

## Verification
The hardest state to reach from the ports is clearing a sticky security enable. That needs a running external oscillator, then a set that is accepted, a rejected clear, a failure pulse, and only then a clear that is accepted. The stimulus reaches it by first stepping the external ready flag up with exact tick counts, then issuing each write in turn. The internal-ready hold is reached the same way: the internal oscillator is let fall to idle, and a use input is then raised while a predivider write is attempted.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned B_XON  = 0;
  localparam int unsigned B_XRDY = 1;
  localparam int unsigned B_BYP  = 2;
  localparam int unsigned B_DRV  = 3;
  localparam int unsigned DRV_W  = 2;
  localparam int unsigned B_CSS  = 5;
  localparam int unsigned B_FAIL = 6;
  localparam int unsigned B_SYS  = 7;
  localparam int unsigned B_SRDY = 8;
  localparam int unsigned B_GF   = 9;
  localparam int unsigned B_TRIM = 10;
  localparam int unsigned B_ION  = 16;
  localparam int unsigned B_IRDY = 17;
  localparam int unsigned B_IDIV = 18;

  typedef enum int unsigned {
    G_EXT = 0,
    G_INT = 1
  } grp_e;
  localparam int unsigned NGRP = 2;
endpackage

// File: rtl/lsc_access_gate.sv
module lsc_access_gate #(
  parameter int unsigned NG = 2
) (
  input  logic          acc_sec_i,
  input  logic          acc_priv_i,
  input  logic          priv_only_i,
  input  logic [NG-1:0] grp_sec_i,
  output logic [NG-1:0] grant_o
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grant_o[g] = (!grp_sec_i[g] || acc_sec_i) && (!priv_only_i || acc_priv_i);
  end
endmodule

// File: rtl/lsc_ready_tracker.sv
module lsc_ready_tracker #(
  parameter int unsigned RISE = 8,
  parameter int unsigned FALL = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic tick_i,
  input  logic force_i,
  output logic rdy_o
);
  localparam int unsigned MAXD = (RISE > FALL) ? RISE : FALL;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam bit          IMM  = (FALL == 0);
  localparam logic [CW-1:0] RT = CW'(RISE - 1);
  localparam logic [CW-1:0] FT = CW'((FALL > 0) ? FALL - 1 : 0);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (force_i) begin
      rdy_o <= 1'b1;
      cnt_q <= '0;
    end else if (want_i == rdy_o) begin
      cnt_q <= '0;
    end else if (IMM && !want_i) begin
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == (want_i ? RT : FT)) begin
        rdy_o <= want_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // flag moves only on a tick, a force, or an immediate drop
  p_tick_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !force_i && !(IMM && !want_i)) |=> $stable(rdy_o));
endmodule

// File: rtl/lsc_ctrl_reg.sv
module lsc_ctrl_reg
  import lsc_pkg::*;
#(
  parameter int unsigned TRIM_W   = 3,
  parameter int unsigned XRISE    = 8,
  parameter int unsigned XFALL    = 6,
  parameter int unsigned SYS_RISE = 2,
  parameter int unsigned IRISE    = 4,
  parameter int unsigned IFALL    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  input  logic              acc_sec_i,
  input  logic              acc_priv_i,
  input  logic              ext_sec_i,
  input  logic              int_sec_i,
  input  logic              priv_only_i,
  output logic [31:0]       rdata_o,
  input  logic              lse_tick_i,
  input  logic              lsi_tick_i,
  input  logic              css_fail_i,
  input  logic              wdg_use_i,
  input  logic              rtc_use_i,
  input  logic [TRIM_W-1:0] trim_cal_i,
  input  logic              opt_load_i,
  output logic              lse_en_o,
  output logic              lsi_en_o
);
  logic [NGRP-1:0] grant;
  logic xon_q, byp_q, gf_q, css_q, fail_q, sys_q, ion_q, idiv_q;
  logic [DRV_W-1:0]  drv_q;
  logic [TRIM_W-1:0] trim_q;
  logic xrdy, sys_rdy, irdy;
  logic css_d, fail_d;
  logic wr_ext, wr_int, xlock, ilock, in_use, x_run;

  lsc_access_gate #(.NG(NGRP)) u_gate (
    .acc_sec_i   (acc_sec_i),
    .acc_priv_i  (acc_priv_i),
    .priv_only_i (priv_only_i),
    .grp_sec_i   ({int_sec_i, ext_sec_i}),
    .grant_o     (grant)
  );

  assign wr_ext = wr_en_i && grant[G_EXT];
  assign wr_int = wr_en_i && grant[G_INT];
  assign xlock  = xon_q || xrdy;
  assign in_use = wdg_use_i || rtc_use_i;
  assign ilock  = ion_q || irdy || in_use;
  // crystal mode needs non-zero drive
  assign x_run  = xon_q && (byp_q || (drv_q != '0));

  always_comb begin
    css_d = css_q;
    if (wr_ext) begin
      if (wdata_i[B_CSS] && !css_q && xrdy)        css_d = 1'b1;
      else if (!wdata_i[B_CSS] && css_q && fail_q) css_d = 1'b0;
    end
    fail_d = css_d && (fail_q || (css_fail_i && css_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xon_q  <= 1'b0;
      byp_q  <= 1'b0;
      drv_q  <= '0;
      gf_q   <= 1'b0;
      trim_q <= trim_cal_i;
      css_q  <= 1'b0;
      fail_q <= 1'b0;
      sys_q  <= 1'b0;
      ion_q  <= 1'b0;
      idiv_q <= 1'b0;
    end else begin
      css_q  <= css_d;
      fail_q <= fail_d;
      if (wr_ext) begin
        xon_q <= wdata_i[B_XON];
        drv_q <= wdata_i[B_DRV +: DRV_W];
        sys_q <= wdata_i[B_SYS];
        if (!xlock) begin
          byp_q  <= wdata_i[B_BYP];
          gf_q   <= wdata_i[B_GF];
          trim_q <= wdata_i[B_TRIM +: TRIM_W];
        end
      end
      if (opt_load_i) trim_q <= trim_cal_i;
      if (wr_int) begin
        ion_q <= wdata_i[B_ION];
        if (!ilock) idiv_q <= wdata_i[B_IDIV];
      end
    end
  end

  lsc_ready_tracker #(.RISE(XRISE), .FALL(XFALL)) u_xrdy (
    .clk_i (clk_i), .rst_ni (rst_ni), .want_i (x_run),
    .tick_i (lse_tick_i), .force_i (1'b0), .rdy_o (xrdy)
  );

  lsc_ready_tracker #(.RISE(SYS_RISE), .FALL(0)) u_srdy (
    .clk_i (clk_i), .rst_ni (rst_ni), .want_i (sys_q && xrdy),
    .tick_i (lse_tick_i), .force_i (1'b0), .rdy_o (sys_rdy)
  );

  lsc_ready_tracker #(.RISE(IRISE), .FALL(IFALL)) u_irdy (
    .clk_i (clk_i), .rst_ni (rst_ni), .want_i (ion_q),
    .tick_i (lsi_tick_i), .force_i (in_use), .rdy_o (irdy)
  );

  logic [31:0] ext_w, int_w;
  always_comb begin
    ext_w = '0;
    ext_w[B_XON]  = xon_q;
    ext_w[B_XRDY] = xrdy;
    ext_w[B_BYP]  = byp_q;
    ext_w[B_DRV +: DRV_W] = drv_q;
    ext_w[B_CSS]  = css_q;
    ext_w[B_FAIL] = fail_q;
    ext_w[B_SYS]  = sys_q;
    ext_w[B_SRDY] = sys_rdy;
    ext_w[B_GF]   = gf_q;
    ext_w[B_TRIM +: TRIM_W] = trim_q;
    int_w = '0;
    int_w[B_ION]  = ion_q;
    int_w[B_IRDY] = irdy;
    int_w[B_IDIV] = idiv_q;
    rdata_o = (grant[G_EXT] ? ext_w : '0) | (grant[G_INT] ? int_w : '0);
  end

  assign lse_en_o = x_run;
  assign lsi_en_o = ion_q;

  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  p_lock_cfg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlock |=> ($stable(byp_q) && $stable(gf_q)));
  p_lock_trim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlock && !opt_load_i) |=> $stable(trim_q));
  p_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xrdy && !byp_q && drv_q == '0) |=> !xrdy);
  p_sys_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xrdy |=> !sys_rdy);
  p_css_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (css_q && !fail_q) |=> css_q);
  p_css_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!css_q && !xrdy) |=> !css_q);
  p_fail_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !css_q |-> !fail_q);
  p_in_use_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_use |=> irdy);
  p_div_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilock |=> $stable(idiv_q));
  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ext |=> ($stable(xon_q) && $stable(drv_q) && $stable(sys_q)));
endmodule

// File: tb/tb_lsc_ctrl_reg.sv
module tb_lsc_ctrl_reg;
  localparam int unsigned TW = 3;
  localparam logic [TW-1:0] CAL = 3'd5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic acc_sec = 1'b1, acc_priv = 1'b1, ext_sec = 1'b0, int_sec = 1'b0, priv_only = 1'b0;
  logic [31:0] rdata;
  logic lse_tick = 1'b0, lsi_tick = 1'b0, css_fail = 1'b0;
  logic wdg_use = 1'b0, rtc_use = 1'b0, opt_load = 1'b0;
  logic lse_en, lsi_en;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsc_ctrl_reg #(.TRIM_W(TW)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .wr_en_i (wr_en), .wdata_i (wdata),
    .acc_sec_i (acc_sec), .acc_priv_i (acc_priv), .ext_sec_i (ext_sec),
    .int_sec_i (int_sec), .priv_only_i (priv_only), .rdata_o (rdata),
    .lse_tick_i (lse_tick), .lsi_tick_i (lsi_tick), .css_fail_i (css_fail),
    .wdg_use_i (wdg_use), .rtc_use_i (rtc_use), .trim_cal_i (CAL),
    .opt_load_i (opt_load), .lse_en_o (lse_en), .lsi_en_o (lsi_en)
  );

  // {ext_sec, int_sec, priv_only, acc_sec, acc_priv, wdata, expected full read}
  localparam logic [68:0] VEC [5] = '{
    {5'b00011, 32'h0004_1A9C, 32'h0004_1A9C},
    {5'b10001, 32'h0000_0000, 32'h0000_1A9C},
    {5'b10010, 32'h0000_0C08, 32'h0000_0C08},
    {5'b00110, 32'h0004_0004, 32'h0000_0C08},
    {5'b01001, 32'h0004_0004, 32'h0000_0004}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic full_attr();
    ext_sec = 1'b0; int_sec = 1'b0; priv_only = 1'b0; acc_sec = 1'b1; acc_priv = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xtick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); lse_tick = 1'b1;
      @(negedge clk); lse_tick = 1'b0;
    end
  endtask

  task automatic itick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); lsi_tick = 1'b1;
      @(negedge clk); lsi_tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [31:0] mask, input logic [31:0] exp, input string tag);
    #1;
    chk(rdata & mask, exp & mask, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd(32'hFFFF_FFFF, 32'h0000_1400, "R10 reset trim load");
    chk({31'b0, lse_en}, 32'h0, "R4 reset lse_en");

    // R9 access-attribute table
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      {ext_sec, int_sec, priv_only, acc_sec, acc_priv} = VEC[i][68:64];
      wr(VEC[i][63:32]);
      full_attr();
      rd(32'hFFFF_FFFF, VEC[i][31:0], $sformatf("R9 vector %0d", i));
    end

    wr(32'h0004_0004);
    ext_sec = 1'b1; acc_sec = 1'b0;
    rd(32'hFFFF_FFFF, 32'h0004_0000, "R9 non-secure read hides group");
    full_attr();

    // R10 option load
    wr(32'h0000_0000);
    rd(32'hFFFF_FFFF, 32'h0, "R3 idle trim write");
    @(negedge clk); opt_load = 1'b1;
    @(negedge clk); opt_load = 1'b0;
    rd(32'hFFFF_FFFF, 32'h0000_1400, "R10 option reload");

    // R4 crystal mode with zero drive
    wr(32'h0000_1401);
    xtick(20);
    rd(32'hFFFF_FFFF, 32'h0000_1401, "R4 no ready with drive 0");
    chk({31'b0, lse_en}, 32'h0, "R4 lse_en low");

    // R1 rise
    wr(32'h0000_1409);
    chk({31'b0, lse_en}, 32'h1, "R1 lse_en high");
    xtick(7);
    rd(32'h2, 32'h0, "R1 ready before 8th tick");
    xtick(1);
    rd(32'h2, 32'h2, "R1 ready on 8th tick");

    // R3 lock while running
    wr(32'h0000_020D);
    rd(32'hFFFF_FFFF, 32'h0000_140B, "R3 locked fields");

    // R2 system clock ready
    wr(32'h0000_1489);
    xtick(1);
    rd(32'h100, 32'h0, "R2 sys ready after 1 tick");
    xtick(1);
    rd(32'hFFFF_FFFF, 32'h0000_158B, "R2 sys ready after 2 ticks");

    // R5/R6 security enable
    wr(32'h0000_14A9);
    rd(32'h60, 32'h20, "R5 set while ready");
    wr(32'h0000_1489);
    rd(32'h60, 32'h20, "R5 clear ignored without failure");
    @(negedge clk); css_fail = 1'b1;
    @(negedge clk); css_fail = 1'b0;
    rd(32'h60, 32'h60, "R6 failure flag set");
    wr(32'h0000_1489);
    rd(32'h60, 32'h00, "R6 clear after failure");
    @(negedge clk); css_fail = 1'b1;
    @(negedge clk); css_fail = 1'b0;
    rd(32'h60, 32'h00, "R6 pulse ignored while disabled");

    // R1 fall, R2 drop
    wr(32'h0000_1408);
    @(negedge clk);
    rd(32'h100, 32'h0, "R2 sys ready drops");
    xtick(5);
    rd(32'h2, 32'h2, "R1 ready held after 5 ticks");
    xtick(1);
    rd(32'h2, 32'h0, "R1 ready drops on 6th tick");
    wr(32'h0000_1428);
    rd(32'h20, 32'h0, "R5 set ignored while not ready");
    wr(32'h0000_0C0C);
    rd(32'hFFFF_FFFF, 32'h0000_0C0C, "R3 write accepted when idle");

    // R7 internal oscillator
    wr(32'h0001_0C0C);
    chk({31'b0, lsi_en}, 32'h1, "R7 lsi_en high");
    itick(3);
    rd(32'h2_0000, 32'h0, "R7 internal ready before 4th tick");
    itick(1);
    rd(32'h2_0000, 32'h2_0000, "R7 internal ready on 4th tick");
    wr(32'h0000_0C0C);
    itick(2);
    rd(32'h2_0000, 32'h2_0000, "R7 internal held after 2 ticks");
    itick(1);
    rd(32'h2_0000, 32'h0, "R7 internal drops on 3rd tick");

    // R7/R8 in-use hold and predivider lock
    @(negedge clk); wdg_use = 1'b1;
    @(negedge clk);
    rd(32'h2_0000, 32'h2_0000, "R7 held by watchdog use");
    wr(32'h0004_0C0C);
    rd(32'h4_0000, 32'h0, "R8 predivider locked while in use");
    wdg_use = 1'b0;
    itick(3);
    rd(32'h2_0000, 32'h0, "R7 drops after use released");
    @(negedge clk); rtc_use = 1'b1;
    @(negedge clk);
    rd(32'h2_0000, 32'h2_0000, "R7 held by rtc use");
    rtc_use = 1'b0;
    itick(3);
    wr(32'h0004_0C0C);
    rd(32'h4_0000, 32'h4_0000, "R8 predivider write when idle");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule